// File: doc/BRIEF.md
# SDRAM Data Mask Timing Pipeline

This block sits in the data path of a synchronous DRAM. It handles the per-byte-lane mask inputs, which behave differently depending on the direction of the transfer. During a write, a lane's mask acts at once as a byte-write blocker. During a read, the same mask acts two clock edges later as an output enable for that lane. The data path can be one byte lane wide or two. In the two-lane form, the lower and upper bytes have separate masks.

The block works alongside a command decoder and a CAS-latency read-data pipeline, and neither of those is part of it. The decoder supplies the transfer direction. The read-data pipeline presents each internal read word together with a valid flag. The block returns three things:

- combinational per-lane write enables for the array,
- a registered read word,
- a registered per-lane output-enable vector.

The output-enable vector stands in for real tristate pads, and a disabled lane is driven as zero. The read mask pipeline keeps shifting on every edge, whatever the transfer direction. A mask raised during a read-to-write turnaround therefore still blanks the trailing read word, so the controller can clear the bus before writing.

Top module: `sdram_mask_timing`

## Requirements
- R1: After a synchronous active-high reset, `dq_oe_o` is all low and `dq_o` is zero. Read words registered at the first two clock edges after reset release stay disabled, because the mask pipeline starts in the masked state.
- R2: While `wr_mode_i` is 1 (write), `wr_be_o[i]` equals the inverse of `mask_i[i]` in the same cycle, with no register in the path. A high mask blocks the byte and a low mask lets it be written.
- R3: While `wr_mode_i` is 0 (read), `wr_be_o` is all zero whatever the masks are.
- R4: The value of `mask_i[i]` sampled at clock edge n governs lane i of the read word registered at edge n+2, which is the word on `rd_data_i` just before that edge. A mask value of 1 drives `dq_oe_o[i]` low for that word.
- R5: `dq_oe_o[i]` goes high only for a word where `rd_valid_i` was high at the edge that registered it.
- R6: Lane i of `dq_o` carries the registered `rd_data_i` lane when `dq_oe_o[i]` is high, and is zero otherwise.
- R7: Lane i spans bits [8i+7:8i] of the data buses. Lane 0 is the lower byte and lane 1 the upper byte. Each lane follows only its own mask bit, in both directions.
- R8: The read mask pipeline advances on every edge regardless of `wr_mode_i`. A mask raised in a write cycle both blocks that write and disables the read word registered two edges later.
- R9: Masks may change on every cycle, and each read word is governed by exactly the mask sampled two edges before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mask_i | input | LANES | Per-lane data mask, active high |
| wr_mode_i | input | 1 | Transfer direction: 1 = write, 0 = read |
| rd_valid_i | input | 1 | Internal read word on `rd_data_i` is valid |
| rd_data_i | input | LANES*LANE_W | Internal read word from the latency pipeline |
| wr_be_o | output | LANES | Per-lane write enable, same cycle as the mask |
| dq_o | output | LANES*LANE_W | Registered read word; disabled lanes are zero |
| dq_oe_o | output | LANES | Registered per-lane output enable |

## Verification
The write enables are combinational, so each one is checked one time step after the bench drives the inputs, in the same cycle and before the clock edge that would latch them. The read outputs are registered. A mask driven before edge n is sampled at n, and its effect is checked after edge n+2 in the middle of the low phase. The bench keeps a two-deep history of sampled masks that starts all-masked at reset. It uses this history to predict each registered word at the edge that captures it, so every comparison is made against the word due in that exact cycle.

// File: rtl/sdram_mask_pkg.sv
package sdram_mask_pkg;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_LANE_W = 8;
  localparam int unsigned DEF_RD_LAT = 2;

  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_WRITE = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/mask_rd_delay.sv
module mask_rd_delay #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] mask_due
);
  localparam int unsigned LAST = RD_LAT - 1;

  logic [RD_LAT-1:0][LANES-1:0] stage;

  // free-running shift chain; reset leaves every lane masked
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '1;
    end else begin
      stage[0] <= mask_in;
      for (int s = 1; s < RD_LAT; s++) begin
        stage[s] <= stage[s-1];
      end
    end
  end

  assign mask_due = stage[LAST];

  generate
    for (genvar s = 1; s < RD_LAT; s++) begin : g_chk
      // R8
      stage_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stage[s] == $past(stage[s-1]));
    end
  endgenerate
endmodule

// File: rtl/mask_wr_gate.sv
module mask_wr_gate
  import sdram_mask_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  xfer_mode_e       mode,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] wr_be
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign wr_be[l] = (mode == MODE_WRITE) && !mask_in[l];
    end
  endgenerate
endmodule

// File: rtl/mask_rd_out.sv
module mask_rd_out #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_valid,
  input  logic [LANES*LANE_W-1:0] rd_data,
  input  logic [LANES-1:0]        mask_due,
  output logic [LANES*LANE_W-1:0] dq,
  output logic [LANES-1:0]        dq_oe
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic drive;
      assign drive = rd_valid && !mask_due[l];

      always_ff @(posedge clk) begin
        if (rst) begin
          dq_oe[l]              <= 1'b0;
          dq[l*LANE_W +: LANE_W] <= '0;
        end else begin
          dq_oe[l]              <= drive;
          dq[l*LANE_W +: LANE_W] <= drive ? rd_data[l*LANE_W +: LANE_W] : '0;
        end
      end

      // R6
      lane_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_oe[l] |-> dq[l*LANE_W +: LANE_W] == '0);
    end
  endgenerate
endmodule

// File: rtl/sdram_mask_timing.sv
module sdram_mask_timing
  import sdram_mask_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned RD_LAT = DEF_RD_LAT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    wr_mode_i,
  input  logic                    rd_valid_i,
  input  logic [LANES*LANE_W-1:0] rd_data_i,
  output logic [LANES-1:0]        wr_be_o,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic [LANES-1:0]        dq_oe_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [LANES-1:0] mask_due;
  xfer_mode_e       mode;

  assign mode = xfer_mode_e'(wr_mode_i);

  mask_wr_gate #(.LANES(LANES)) u_wr_gate (
    .mode    (mode),
    .mask_in (mask_i),
    .wr_be   (wr_be_o)
  );

  mask_rd_delay #(.LANES(LANES), .RD_LAT(RD_LAT)) u_rd_delay (
    .clk      (clk),
    .rst      (rst),
    .mask_in  (mask_i),
    .mask_due (mask_due)
  );

  mask_rd_out #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_out (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid_i),
    .rd_data  (rd_data_i),
    .mask_due (mask_due),
    .dq       (dq_o),
    .dq_oe    (dq_oe_o)
  );

  // R2
  wr_mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_be_o & mask_i) == '0);

  // R3
  wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_mode_i |-> wr_be_o == '0);

  // R5
  rd_valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_oe_o != '0) |-> $past(rd_valid_i));

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      // R6
      rd_data_pass_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe_o[l] |-> dq_o[l*LANE_W +: LANE_W] == $past(rd_data_i[l*LANE_W +: LANE_W]));
      if (RD_LAT == 2) begin : g_lat2
        // R4
        rd_mask_lat_chk: assert property (@(posedge clk) disable iff (rst)
          dq_oe_o[l] |-> !$past(mask_i[l], 3));
      end
    end
  endgenerate

  initial begin
    if (DW == 0 || RD_LAT == 0) $error("sdram_mask_timing: bad parameters");
  end
endmodule

// File: tb/sdram_mask_timing_bench.sv
module sdram_mask_timing_bench;
  localparam int LANES = 2;
  localparam int LANE_W = 8;
  localparam int DW = LANES * LANE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0] mask_i = '0;
  logic wr_mode_i = 1'b0;
  logic rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic [LANES-1:0] wr_be_o;
  logic [DW-1:0] dq_o;
  logic [LANES-1:0] dq_oe_o;

  int vectors = 0;
  int miscompares = 0;

  // bench-side mask history: h0 newest sampled mask, h1 the one before
  logic [LANES-1:0] h0 = '1;
  logic [LANES-1:0] h1 = '1;
  logic [LANES-1:0] e_oe;
  logic [DW-1:0] e_dq;

  always #10 clk = ~clk;

  sdram_mask_timing #(.LANES(LANES), .LANE_W(LANE_W), .RD_LAT(2)) u_sdram_mask_timing (
    .clk(clk), .rst(rst), .mask_i(mask_i), .wr_mode_i(wr_mode_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .wr_be_o(wr_be_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check write enables, clock, check read outputs
  task automatic cyc(input logic [LANES-1:0] m, input logic wm, input logic rv,
                     input logic [DW-1:0] rd, input string wreq, input string rreq);
    mask_i = m; wr_mode_i = wm; rd_valid_i = rv; rd_data_i = rd;
    #1;
    check(wreq, "wr_be", {30'd0, wr_be_o}, {30'd0, (wm ? ~m : 2'b00)});
    @(posedge clk);
    e_oe = rv ? ~h1 : 2'b00;
    h1 = h0;
    h0 = m;
    e_dq = {(e_oe[1] ? rd[15:8] : 8'h00), (e_oe[0] ? rd[7:0] : 8'h00)};
    @(negedge clk);
    check(rreq, "dq_oe", {30'd0, dq_oe_o}, {30'd0, e_oe});
    check(rreq, "dq", {16'd0, dq_o}, {16'd0, e_dq});
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; mask_i = '0; wr_mode_i = 1'b0; rd_valid_i = 1'b1; rd_data_i = 16'hFFFF;
    @(posedge clk); @(posedge clk);
    h0 = '1; h1 = '1;
    @(negedge clk);
    check("R1", "dq_oe after reset", {30'd0, dq_oe_o}, 32'd0);
    check("R1", "dq after reset", {16'd0, dq_o}, 32'd0);
    rst = 1'b0;
    // first two read words after release stay disabled
    cyc(2'b00, 1'b0, 1'b1, 16'hA1B2, "R3", "R1");
    cyc(2'b00, 1'b0, 1'b1, 16'hC3D4, "R3", "R1");
    cyc(2'b00, 1'b0, 1'b1, 16'hE5F6, "R3", "R4");
  endtask

  task automatic t_write_lanes;
    cyc(2'b00, 1'b1, 1'b0, 16'h0000, "R2", "R5");
    cyc(2'b01, 1'b1, 1'b0, 16'h0000, "R7", "R5");
    cyc(2'b10, 1'b1, 1'b0, 16'h0000, "R7", "R5");
    cyc(2'b11, 1'b1, 1'b0, 16'h0000, "R2", "R5");
  endtask

  task automatic t_write_off;
    cyc(2'b00, 1'b0, 1'b0, 16'h1234, "R3", "R5");
    cyc(2'b11, 1'b0, 1'b0, 16'h5678, "R3", "R5");
    cyc(2'b01, 1'b0, 1'b0, 16'h9ABC, "R3", "R5");
  endtask

  task automatic t_read_pulse;
    cyc(2'b00, 1'b0, 1'b1, 16'h1111, "R3", "R4");
    cyc(2'b01, 1'b0, 1'b1, 16'h2222, "R3", "R4");
    cyc(2'b00, 1'b0, 1'b1, 16'h3333, "R3", "R4");
    cyc(2'b00, 1'b0, 1'b1, 16'h4444, "R3", "R7");
    cyc(2'b10, 1'b0, 1'b1, 16'h5555, "R3", "R4");
    cyc(2'b00, 1'b0, 1'b1, 16'h6666, "R3", "R6");
    cyc(2'b00, 1'b0, 1'b1, 16'h7777, "R3", "R7");
    cyc(2'b00, 1'b0, 1'b1, 16'h8888, "R3", "R6");
  endtask

  task automatic t_valid_gap;
    cyc(2'b00, 1'b0, 1'b0, 16'hDEAD, "R3", "R5");
    cyc(2'b00, 1'b0, 1'b1, 16'hBEEF, "R3", "R6");
    cyc(2'b00, 1'b0, 1'b0, 16'hCAFE, "R3", "R5");
    cyc(2'b00, 1'b0, 1'b1, 16'hF00D, "R3", "R6");
  endtask

  task automatic t_turnaround;
    cyc(2'b00, 1'b0, 1'b1, 16'h0A0B, "R3", "R6");
    cyc(2'b11, 1'b1, 1'b1, 16'h0C0D, "R8", "R8");
    cyc(2'b00, 1'b1, 1'b1, 16'h0E0F, "R8", "R8");
    cyc(2'b00, 1'b1, 1'b1, 16'h1A1B, "R2", "R8");
    cyc(2'b00, 1'b1, 1'b0, 16'h1C1D, "R2", "R8");
  endtask

  task automatic t_toggle;
    cyc(2'b01, 1'b0, 1'b1, 16'h2121, "R3", "R9");
    cyc(2'b10, 1'b0, 1'b1, 16'h4343, "R3", "R9");
    cyc(2'b01, 1'b0, 1'b1, 16'h6565, "R3", "R9");
    cyc(2'b10, 1'b0, 1'b1, 16'h8787, "R3", "R9");
    cyc(2'b11, 1'b0, 1'b1, 16'hA9A9, "R3", "R9");
    cyc(2'b00, 1'b0, 1'b1, 16'hCBCB, "R3", "R9");
    cyc(2'b00, 1'b0, 1'b1, 16'hEDED, "R3", "R9");
    cyc(2'b00, 1'b0, 1'b1, 16'h0F0F, "R3", "R9");
  endtask

  initial begin
    t_reset();
    t_write_lanes();
    t_write_off();
    t_read_pulse();
    t_valid_gap();
    t_turnaround();
    t_toggle();
    t_reset();
    t_read_pulse();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule